// File: doc/BRIEF.md
# Dual-DAC Channel Write Controller

This block sits between a small host register window and two serial 12-bit DAC chips, each of which holds two output channels, giving four outputs in all. The host places a 16-bit command into a command register. The command holds a 12-bit output code, a settling-speed flag, a buffer-only flag and a 2-bit channel number. Once the upper half of that register is written, the block sends one 16-bit serial frame to the chip that owns the chosen channel.

The serial clock and data lines are shared by both chips. Each chip has its own active-low select, and only the addressed chip sees its select go low. A buffer-only command parks a code in the addressed chip's holding buffer and leaves its outputs alone. A later ordinary write to the second channel of that chip then moves both of its outputs at the same instant. A status byte tells the host when a new command can be taken. An upper-half write that arrives while a frame is in flight is dropped.

The host may write the command as one 16-bit word at offset 4, or as two bytes, low byte first at offset 4 and then high byte at offset 5.

Top module: `dacpair_write_ctrl`

## Requirements
- R1: After reset the command register reads 0x0000 at offset 4, both chip selects are high, the serial clock is low and the status byte at offset 6 reads 0x80.
- R2: A byte write to offset 4 updates only command bits 7:0. It starts no frame, and the status byte stays 0x80.
- R3: A byte write to offset 5 (loading bits 15:8) or a 16-bit write at offset 4 launches exactly one frame when accepted. Offset 4 reads back the full 16-bit command.
- R4: A frame is 16 bits, most significant bit first, and each bit is valid at a rising serial-clock edge. Bits 15:12 are control {update, speed, power, target} and bits 11:0 are the command code. The power bit is always 0, and the clock is low whenever no chip is selected.
- R5: Command bit 15 picks the chip: 0 drives select line 0 (channels 1 and 2, codes 00 and 01) and 1 drives select line 1 (channels 3 and 4, codes 10 and 11). At most one select is low at a time.
- R6: For an ordinary write (bit 13 clear), update is 1 and target equals command bit 14.
- R7: For a buffer-only write (bit 13 set), update and target are both 0. The chip is chosen by bit 15 alone, and bit 14 has no effect on the frame.
- R8: The speed bit of the frame equals command bit 12.
- R9: Bit 7 of offset 6 is ready and bits 6:0 read 0. Ready reads 0 from the clock after an accepted launch until the edge at which the select returns high, and it reads 1 from that edge on.
- R10: While ready is 0, a byte write to offset 5 and a 16-bit write at offset 4 are discarded: the command register keeps its value and no frame follows. A low-byte write is still taken.
- R11: Each serial-clock phase lasts SCLK_HALF system clocks, so a select stays low for exactly 32*SCLK_HALF clocks per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access on bus_wdata[7:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| dac_sclk | output | 1 | Shared serial clock, idle low |
| dac_sdo | output | 1 | Shared serial data |
| dac_cs_n | output | 2 | Per-chip active-low select |

## Verification
A launch write is sampled at clock edge E0. The status byte drops at E0, the select falls one clock later at E1, and the select returns high together with ready 32*SCLK_HALF clocks after E1. Register readback is combinational and is due right after the write edge. The bench drives the bus and samples everything on falling clock edges, half a period away from each update. Its monitor captures a data bit when it sees the serial clock newly high on such a sample. It compares a finished frame against the head of the expected queue only when it sees the select high again, and the frame-timing task counts clocks of low select against 32*SCLK_HALF.

// File: rtl/dacpair_pkg.sv
// Package: shared widths, register offsets and the command layout
// used by the dual-DAC write controller. No logic state lives here.
package dacpair_pkg;

    localparam int CODE_W  = 12;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 16;

    localparam logic [2:0] OFS_CMD_LO = 3'd4;
    localparam logic [2:0] OFS_CMD_HI = 3'd5;
    localparam logic [2:0] OFS_STATUS = 3'd6;

    // Command register layout; the bit positions are decoded by the frame map.
    typedef struct packed {
        logic [1:0]        chan;      // 15:14 channel number, 00 = first
        logic              buf_only;  // 13    load holding buffer only
        logic              fast;      // 12    fast settling
        logic [CODE_W-1:0] code;      // 11:0  output code
    } dac_cmd_t;

    // Control nibble at the head of each serial frame.
    typedef struct packed {
        logic update;   // 1 = move data to an output
        logic speed;    // 1 = fast settling
        logic power;    // 1 = power down
        logic target;   // 1 = second channel of the chip
    } frame_ctrl_t;

endpackage

// File: rtl/dacpair_host_regs.sv
// Host register window: holds the 16-bit command, accepts byte and word
// writes, raises a one-clock launch pulse after an accepted upper-half
// write and returns read data combinationally.
// Assumes one write strobe per access and that `ready` is 1 only when the
// serial engine can take a new frame.
module dacpair_host_regs
    import dacpair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_word,
    input  logic [CMD_W-1:0] bus_wdata,
    input  logic             ready,
    output logic [CMD_W-1:0] cmd_bits,
    output logic             launch,
    output logic [CMD_W-1:0] bus_rdata
);

    localparam int BYTE_W = CMD_W / 2;

    logic [CMD_W-1:0] cmd_q;
    logic             launch_q;
    logic             wr_lo_byte;
    logic             wr_hi_byte;
    logic             wr_word;
    logic             trig_ok;

    // Decode the kind of access this clock.
    always_comb begin
        wr_lo_byte = bus_wr && !bus_word && (bus_addr == OFS_CMD_LO);
        wr_hi_byte = bus_wr && !bus_word && (bus_addr == OFS_CMD_HI);
        wr_word    = bus_wr &&  bus_word && (bus_addr == OFS_CMD_LO);
        trig_ok    = (wr_hi_byte || wr_word) && ready;
    end

    // Update the command register and register the launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= trig_ok;
            if (wr_word && ready) begin
                cmd_q <= bus_wdata;
            end else begin
                if (wr_lo_byte) begin
                    cmd_q[BYTE_W-1:0] <= bus_wdata[BYTE_W-1:0];
                end
                if (wr_hi_byte && ready) begin
                    cmd_q[CMD_W-1:BYTE_W] <= bus_wdata[BYTE_W-1:0];
                end
            end
        end
    end

    // Select the read data for the addressed offset.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CMD_LO: bus_rdata = cmd_q;
            OFS_CMD_HI: bus_rdata[BYTE_W-1:0] = cmd_q[CMD_W-1:BYTE_W];
            OFS_STATUS: bus_rdata[BYTE_W-1] = ready;
            default:    bus_rdata = '0;
        endcase
    end

    assign cmd_bits = cmd_q;
    assign launch   = launch_q;

endmodule

// File: rtl/dacpair_frame_map.sv
// Frame map: turns a command into the 16-bit serial word and picks which
// chip receives it. Purely combinational; assumes a stable command while
// the launch pulse is high.
module dacpair_frame_map
    import dacpair_pkg::*;
#(
    parameter bit PWR_DOWN = 1'b0
) (
    input  dac_cmd_t             cmd,
    output logic [FRAME_W-1:0]   frame,
    output logic                 chip
);

    frame_ctrl_t ctrl;

    // Map the command flags onto the chip's control nibble.
    always_comb begin
        ctrl.update = !cmd.buf_only;
        ctrl.speed  = cmd.fast;
        ctrl.power  = PWR_DOWN;
        ctrl.target = cmd.buf_only ? 1'b0 : cmd.chan[0];
        frame       = {ctrl, cmd.code};
        chip        = cmd.chan[1];
    end

endmodule

// File: rtl/dacpair_serial_engine.sv
// Serial engine: shifts one frame out MSB first on a shared clock/data
// pair with a per-chip active-low select. Data changes while the clock is
// low and is stable across each rising edge. Assumes launch arrives only
// while idle.
module dacpair_serial_engine #(
    parameter int SCLK_HALF = 2,
    parameter int FRAME_W   = 16,
    parameter int N_CHIPS   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CHIP_W-1:0]  chip,
    output logic               busy,
    output logic               sclk,
    output logic               sdo,
    output logic [N_CHIPS-1:0] cs_n
);

    localparam int CHIP_W = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1;
    localparam int CNT_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W  = $clog2(FRAME_W);

    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} eng_state_t;

    eng_state_t         state;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   phase_cnt;
    logic [BIT_W-1:0]   bits_left;
    logic [N_CHIPS-1:0] sel_n;

    // One select line per chip, low only for the addressed chip.
    for (genvar g = 0; g < N_CHIPS; g++) begin : g_sel
        assign sel_n[g] = (chip != CHIP_W'(g));
    end

    // Sequence the clock phases and the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            phase_cnt <= '0;
            bits_left <= '0;
            sclk      <= 1'b0;
            cs_n      <= '1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        shreg     <= frame;
                        cs_n      <= sel_n;
                        phase_cnt <= CNT_W'(SCLK_HALF - 1);
                        bits_left <= BIT_W'(FRAME_W - 1);
                        state     <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (phase_cnt == '0) begin
                        sclk      <= 1'b1;
                        phase_cnt <= CNT_W'(SCLK_HALF - 1);
                        state     <= ST_HIGH;
                    end else begin
                        phase_cnt <= phase_cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (phase_cnt == '0) begin
                        sclk <= 1'b0;
                        if (bits_left == '0) begin
                            cs_n  <= '1;
                            state <= ST_IDLE;
                        end else begin
                            shreg     <= {shreg[FRAME_W-2:0], 1'b0};
                            bits_left <= bits_left - 1'b1;
                            phase_cnt <= CNT_W'(SCLK_HALF - 1);
                            state     <= ST_LOW;
                        end
                    end else begin
                        phase_cnt <= phase_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sdo  = shreg[FRAME_W-1];
    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dacpair_write_ctrl.sv
// Top: dual-DAC channel write controller. Joins the host register window,
// the command-to-frame map and the serial engine. Ready is low from the
// clock after an accepted launch until the select returns high.
// Assumes a single clock domain and a synchronous active-low reset.
module dacpair_write_ctrl
    import dacpair_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_word,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        dac_sclk,
    output logic        dac_sdo,
    output logic [1:0]  dac_cs_n
);

    logic [CMD_W-1:0]   cmd_bits;
    logic               launch_q;
    logic               eng_busy;
    logic               ready;
    logic [FRAME_W-1:0] frame;
    logic               chip;

    // Ready when neither a launch is pending nor a frame is in flight.
    assign ready = !eng_busy && !launch_q;

    dacpair_host_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .ready     (ready),
        .cmd_bits  (cmd_bits),
        .launch    (launch_q),
        .bus_rdata (bus_rdata)
    );

    dacpair_frame_map u_map (
        .cmd   (dac_cmd_t'(cmd_bits)),
        .frame (frame),
        .chip  (chip)
    );

    dacpair_serial_engine #(
        .SCLK_HALF (SCLK_HALF),
        .FRAME_W   (FRAME_W),
        .N_CHIPS   (2)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch_q),
        .frame  (frame),
        .chip   (chip),
        .busy   (eng_busy),
        .sclk   (dac_sclk),
        .sdo    (dac_sdo),
        .cs_n   (dac_cs_n)
    );

endmodule

// File: rtl/dacpair_write_ctrl_checker.sv
// Checker: temporal properties of the dual-DAC write controller, bound to
// the top. Observes the selects, serial clock, ready, launch and the upper
// command byte; holds a counter for the frame-length window.
module dacpair_write_ctrl_checker #(
    parameter int SCLK_HALF = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cs_n,
    input logic       sclk,
    input logic       ready,
    input logic       launch,
    input logic [7:0] cmd_hi
);

    localparam int FRAME_CYC = 32 * SCLK_HALF;

    logic        cs_active;
    logic [31:0] low_cnt;

    assign cs_active = (cs_n != 2'b11);

    // Count clocks during which a select is low.
    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= '0;
        else if (cs_active) low_cnt <= low_cnt + 1;
        else                low_cnt <= '0;
    end

    a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r9_not_ready_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_active |-> !ready);

    a_r3_launch_selects: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> cs_active);

    a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |-> !sclk);

    a_r10_upper_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(cmd_hi));

    a_r11_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_active) |-> (low_cnt == 32'(FRAME_CYC)));

endmodule

bind dacpair_write_ctrl dacpair_write_ctrl_checker #(.SCLK_HALF(SCLK_HALF)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (dac_cs_n),
    .sclk   (dac_sclk),
    .ready  (ready),
    .launch (launch_q),
    .cmd_hi (cmd_bits[15:8])
);

// File: tb/test_dacpair_write_ctrl.sv
// Scoreboard bench: the driver pushes expected {chip, frame} items, the
// monitor rebuilds each frame from the serial pins and compares.
module test_dacpair_write_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int FRAME_CYC  = 32 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        dac_sclk;
    logic        dac_sdo;
    logic [1:0]  dac_cs_n;

    int errors = 0;
    int checks = 0;
    int frames_seen = 0;
    int frames_pushed = 0;
    bit done = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dacpair_write_ctrl #(.SCLK_HALF(HALF)) i_dacpair_write_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dac_sclk  (dac_sclk),
        .dac_sdo   (dac_sdo),
        .dac_cs_n  (dac_cs_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected frame from the requirements R4-R8.
    function automatic logic [16:0] expect_frame(input logic [15:0] c);
        logic [3:0] ctl;
        if (c[13]) ctl = {1'b0, c[12], 1'b0, 1'b0};
        else       ctl = {1'b1, c[12], 1'b0, c[14]};
        return {c[15], ctl, c[11:0]};
    endfunction

    // One bus write; called and returns on a falling edge.
    task automatic bus_put(input logic [2:0] a, input logic w, input logic [15:0] d);
        bus_addr  = a;
        bus_word  = w;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_word = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, {16'h0, bus_rdata}, {16'h0, exp});
    endtask

    // After a launch write: ready low at once, select timing, ready back.
    task automatic wait_frame();
        int n;
        int guard;
        read_chk("R9 ready low after launch", 3'd6, 16'h0000);
        guard = 0;
        while (dac_cs_n == 2'b11 && guard < 10) begin
            @(negedge clk);
            guard++;
        end
        n = 0;
        while (dac_cs_n != 2'b11 && n < 10 * FRAME_CYC) begin
            n++;
            @(negedge clk);
        end
        check("R11 select low length", n, FRAME_CYC);
        read_chk("R9 ready back at release", 3'd6, 16'h0080);
    endtask

    task automatic send_word(input string tag, input logic [15:0] c);
        exp_q.push_back(expect_frame(c));
        tag_q.push_back(tag);
        frames_pushed++;
        bus_put(3'd4, 1'b1, c);
        wait_frame();
    endtask

    // Monitor: rebuild frames from the pins on falling clock edges.
    initial begin : monitor
        logic        prev_sclk;
        logic        prev_act;
        logic [15:0] sh;
        logic [1:0]  cs_seen;
        int          nbits;
        prev_sclk = 1'b0;
        prev_act  = 1'b0;
        sh = '0; cs_seen = 2'b11; nbits = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (dac_cs_n != 2'b11) begin
                    if (!prev_act) begin
                        nbits = 0;
                        cs_seen = dac_cs_n;
                    end
                    if (dac_sclk && !prev_sclk) begin
                        sh = {sh[14:0], dac_sdo};
                        nbits++;
                    end
                    prev_act = 1'b1;
                end else if (prev_act) begin
                    prev_act = 1'b0;
                    frames_seen++;
                    if (exp_q.size() == 0) begin
                        check("R10 unexpected frame", {15'h0, cs_seen, sh}, 32'hFFFF_FFFF);
                    end else begin
                        logic [16:0] e;
                        string       t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check({t, " frame bits"}, {16'h0, sh}, {16'h0, e[15:0]});
                        check({t, " R5 chip select"}, {30'h0, cs_seen}, e[16] ? 32'h1 : 32'h2);
                        check({t, " R4 bit count"}, nbits, 16);
                    end
                end
                prev_sclk = dac_sclk;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 selects idle", {30'h0, dac_cs_n}, 32'h3);
        check("R1 sclk low", {31'h0, dac_sclk}, 32'h0);
        read_chk("R1 command zero", 3'd4, 16'h0000);
        read_chk("R1 status ready", 3'd6, 16'h0080);

        // R2 low byte only
        bus_put(3'd4, 1'b0, 16'hEEA5);
        repeat (20) @(negedge clk);
        check("R2 no frame", frames_seen, 0);
        read_chk("R2 low byte latched", 3'd4, 16'h00A5);
        read_chk("R2 status unchanged", 3'd6, 16'h0080);

        // R3 upper byte launches: 0x10A5 -> ch1 fast
        exp_q.push_back(expect_frame(16'h10A5));
        tag_q.push_back("R3 R8 byte launch ch1 fast");
        frames_pushed++;
        bus_put(3'd5, 1'b0, 16'h0010);
        wait_frame();
        read_chk("R3 word readback", 3'd4, 16'h10A5);
        read_chk("R3 upper readback", 3'd5, 16'h0010);

        // R6 ordinary writes on every channel
        send_word("R6 ch2 slow", 16'h4123);
        send_word("R6 R5 ch3 slow", 16'h8FFF);
        send_word("R6 R8 ch4 fast", 16'hD000);
        read_chk("R3 word readback ch4", 3'd4, 16'hD000);

        // R7 buffer-only: bit 14 has no effect
        send_word("R7 buffer chip0", 16'h2ABC);
        send_word("R7 buffer chip0 bit14 set", 16'h6ABC);
        send_word("R7 R8 buffer chip1 fast", 16'hB555);
        send_word("R6 paired ch2 after buffer", 16'h4777);

        // R10 writes while busy
        exp_q.push_back(expect_frame(16'h1234));
        tag_q.push_back("R10 frame before busy writes");
        frames_pushed++;
        bus_put(3'd4, 1'b1, 16'h1234);
        bus_put(3'd4, 1'b1, 16'hFFFF);
        bus_put(3'd5, 1'b0, 16'h00C3);
        bus_put(3'd4, 1'b0, 16'h0077);
        read_chk("R10 upper held while busy", 3'd4, 16'h1277);
        begin
            int g;
            g = 0;
            while (dac_cs_n == 2'b11 && g < 10) begin @(negedge clk); g++; end
            g = 0;
            while (dac_cs_n != 2'b11 && g < 10 * FRAME_CYC) begin @(negedge clk); g++; end
        end
        repeat (3 * FRAME_CYC) @(negedge clk);
        check("R10 frame count", frames_seen, frames_pushed);
        check("R10 queue empty", exp_q.size(), 0);
        read_chk("R10 command after busy", 3'd4, 16'h1277);

        // Back-to-back launch right after ready
        send_word("R3 back-to-back ch3", 16'h8001);
        send_word("R3 back-to-back ch1", 16'h0FFE);

        repeat (5) @(negedge clk);
        check("R3 all frames seen", frames_seen, frames_pushed);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule